// File: doc/BRIEF.md
# TDM Bit Clock and Frame Sync Generator

This block produces the timing for a telephony-style time-division multiplexed serial bus. A programmable prescaler divides the system clock down to a bit clock. A frame counter divides the bit clock down to frames, and one frame-sync pulse marks the start of each frame. The sync is active low and one bit period wide. It is launched on the bit-clock falling edge that comes half a bit period before the rising edge that starts bit 0. A one-cycle strobe marks every bit-clock rising edge, so that downstream shifters can count bits without sampling the slow clock.

Software programs both divider inputs first and raises `enable` last. The bit-clock rate is the system rate divided by 2 × (clkDiv + 1). The frame length is frameDiv + 1 bit clocks, so a frameDiv of 1023 gives 1024 bits per frame. For example, a 8.192 MHz bit clock with frameDiv = 1023 gives a 125 µs frame. The dividers are captured at each frame boundary, so a rewrite during a frame never shortens or stretches the frame in progress.

Top module: `tdm_sync_gen`

## Requirements
- R1: While `enable` is low, from the first clock edge at which it is sampled low: `bitClk` = 0, `frameSyncN` = 1 and `bitStrobe` = 0.
- R2: Each high phase and each low phase of `bitClk` lasts exactly clkDiv + 1 system cycles, so one bit period is 2 × (clkDiv + 1) cycles.
- R3: `frameSyncN` stays low for exactly one bit period, 2 × (clkDiv + 1) cycles. It returns high in the same cycle as a `bitClk` falling edge.
- R4: `frameSyncN` falls in the same cycle as a `bitClk` falling edge, or at start-up. The next `bitClk` rising edge, which starts bit 0, follows clkDiv + 1 cycles later.
- R5: A frame is frameDiv + 1 bit clocks (frameDiv ≥ 1). Successive `frameSyncN` falling edges are (frameDiv + 1) × 2 × (clkDiv + 1) cycles apart, with exactly frameDiv + 1 `bitStrobe` pulses between them.
- R6: `bitStrobe` is high for one cycle, exactly the first cycle in which `bitClk` is high. It is never high at any other time.
- R7: When `enable` is first sampled high, in the following cycle `frameSyncN` is 0 and `bitClk` is 0. The first `bitClk` rise comes clkDiv + 1 cycles after that.
- R8: Values written to `clkDiv` or `frameDiv` during a frame do not affect that frame. They take effect from the next `frameSyncN` falling edge.
- R9: Dropping `enable` in mid-frame and raising it again restarts from bit 0, with the same timing as R7. No count survives the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkDiv | input | CLK_DIV_W | Half-period length of the bit clock, minus one, in system cycles |
| frameDiv | input | FRAME_DIV_W | Frame length in bit clocks, minus one |
| enable | input | 1 | Runs the generator; raised last, once both dividers are set |
| bitClk | output | 1 | Generated bit clock |
| frameSyncN | output | 1 | Active-low frame sync, one bit period wide |
| bitStrobe | output | 1 | One-cycle pulse at each bit-clock rising edge |

## Verification
The hardest case to reach from the ports is a divider rewrite that lands strictly inside a frame. To show it is deferred, the old frame must be measured to its end and the new frame in full. The bench starts a short frame and rewrites both dividers a few cycles in. It then times three consecutive sync falling edges: the first interval must match the old settings and the second the new ones. A second case drops `enable` in the middle of a frame and raises it again with a different divider. Start-up timing that is exact from the first cycle shows that nothing was left over from the pause.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  // Strobes from the sequencing control to the pin datapath
  typedef struct packed {
    logic hold;      // generator disabled: force idle levels
    logic start;     // first enabled cycle: start-up falling edge
    logic rise;      // bit clock rising edge this cycle
    logic fall;      // bit clock falling edge this cycle
    logic boundary;  // falling edge that opens a new frame
  } tdmStrobe_t;

endpackage

// File: rtl/tdm_seq_ctrl.sv
module tdm_seq_ctrl
  import tdm_pkg::*;
#(
  parameter int CLK_DIV_W   = 16,
  parameter int FRAME_DIV_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [CLK_DIV_W-1:0]   clkDiv,
  input  logic [FRAME_DIV_W-1:0] frameDiv,
  output tdmStrobe_t             strb
);

  localparam logic [CLK_DIV_W-1:0]   PRESC_ZERO = '0;
  localparam logic [FRAME_DIV_W-1:0] BIT_ZERO   = '0;

  logic                   running;
  logic                   phaseHigh;
  logic [CLK_DIV_W-1:0]   presc;
  logic [CLK_DIV_W-1:0]   clkDivQ;
  logic [FRAME_DIV_W-1:0] bitIdx;
  logic [FRAME_DIV_W-1:0] frameDivQ;

  logic halfDone;
  logic startNow;
  logic riseNow;
  logic fallNow;
  logic frameEdge;

  always_comb begin
    halfDone  = running && enable && (presc == clkDivQ);
    startNow  = enable && !running;
    riseNow   = halfDone && !phaseHigh;
    fallNow   = halfDone && phaseHigh;
    frameEdge = fallNow && (bitIdx == BIT_ZERO);
  end

  always_comb begin
    strb.hold     = !enable;
    strb.start    = startNow;
    strb.rise     = riseNow;
    strb.fall     = fallNow;
    strb.boundary = frameEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      phaseHigh <= 1'b0;
      presc     <= PRESC_ZERO;
      bitIdx    <= BIT_ZERO;
      clkDivQ   <= PRESC_ZERO;
      frameDivQ <= BIT_ZERO;
    end else if (!enable) begin
      running   <= 1'b0;
      phaseHigh <= 1'b0;
      presc     <= PRESC_ZERO;
      bitIdx    <= BIT_ZERO;
    end else if (startNow) begin
      running   <= 1'b1;
      phaseHigh <= 1'b0;
      presc     <= PRESC_ZERO;
      bitIdx    <= BIT_ZERO;
      clkDivQ   <= clkDiv;
      frameDivQ <= frameDiv;
    end else if (halfDone) begin
      presc <= PRESC_ZERO;
      if (phaseHigh) begin
        phaseHigh <= 1'b0;
        if (frameEdge) begin
          clkDivQ   <= clkDiv;
          frameDivQ <= frameDiv;
        end
      end else begin
        phaseHigh <= 1'b1;
        if (bitIdx == frameDivQ) bitIdx <= BIT_ZERO;
        else                     bitIdx <= bitIdx + 1'b1;
      end
    end else begin
      presc <= presc + 1'b1;
    end
  end

  // R2: the prescaler never runs past the captured half-period limit
  p_presc_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (presc <= clkDivQ));

  // R5: the bit index stays inside the captured frame length
  p_bit_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (bitIdx <= frameDivQ));

  // R8: captured dividers change only at start-up or at a frame boundary
  p_div_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !$past(frameEdge))
      |-> ($stable(clkDivQ) && $stable(frameDivQ)));

  // R6: at most one edge event per cycle
  p_edge_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startNow, riseNow, fallNow}));

endmodule

// File: rtl/tdm_pin_drive.sv
module tdm_pin_drive
  import tdm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tdmStrobe_t strb,
  output logic       bitClk,
  output logic       frameSyncN,
  output logic       bitStrobe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClk     <= 1'b0;
      frameSyncN <= 1'b1;
      bitStrobe  <= 1'b0;
    end else if (strb.hold) begin
      bitClk     <= 1'b0;
      frameSyncN <= 1'b1;
      bitStrobe  <= 1'b0;
    end else begin
      bitStrobe <= strb.rise;
      if (strb.start) frameSyncN <= 1'b0;
      if (strb.rise)  bitClk     <= 1'b1;
      if (strb.fall) begin
        bitClk     <= 1'b0;
        frameSyncN <= !strb.boundary;
      end
    end
  end

  // R1: a disabled cycle leaves all outputs idle
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.hold |=> (!bitClk && frameSyncN && !bitStrobe));

  // R6: the strobe marks only the first high cycle of the bit clock
  p_strobe_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> (bitClk && !$past(bitClk)));

  // R4: the sync is asserted only while the bit clock is low
  p_sync_low_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameSyncN) |-> !bitClk);

  // R3: the sync is released on a bit clock falling edge or by disable
  p_sync_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSyncN) |-> ($fell(bitClk) || $past(strb.hold)));

endmodule

// File: rtl/tdm_sync_gen.sv
module tdm_sync_gen
  import tdm_pkg::*;
#(
  parameter int CLK_DIV_W   = 16,
  parameter int FRAME_DIV_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CLK_DIV_W-1:0]   clkDiv,
  input  logic [FRAME_DIV_W-1:0] frameDiv,
  input  logic                   enable,
  output logic                   bitClk,
  output logic                   frameSyncN,
  output logic                   bitStrobe
);

  tdmStrobe_t strb;

  tdm_seq_ctrl #(
    .CLK_DIV_W  (CLK_DIV_W),
    .FRAME_DIV_W(FRAME_DIV_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .clkDiv  (clkDiv),
    .frameDiv(frameDiv),
    .strb    (strb)
  );

  tdm_pin_drive u_drive (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bitClk    (bitClk),
    .frameSyncN(frameSyncN),
    .bitStrobe (bitStrobe)
  );

endmodule

// File: tb/tdm_sync_gen_bench.sv
module tdm_sync_gen_bench;

  localparam int CW = 16;
  localparam int FW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] clkDiv = '0;
  logic [FW-1:0] frameDiv = '0;
  logic          enable = 1'b0;
  logic          bitClk;
  logic          frameSyncN;
  logic          bitStrobe;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tdm_sync_gen #(.CLK_DIV_W(CW), .FRAME_DIV_W(FW)) u_tdm_sync_gen (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .frameDiv(frameDiv),
    .enable(enable), .bitClk(bitClk), .frameSyncN(frameSyncN),
    .bitStrobe(bitStrobe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(bitClk == 1'b0, "R1 reset bitClk", int'(bitClk), 0);
    check(frameSyncN == 1'b1, "R1 reset frameSyncN", int'(frameSyncN), 1);
    check(bitStrobe == 1'b0, "R1 reset bitStrobe", int'(bitStrobe), 0);
  endtask

  // Runs a number of frames and times every edge against the requirements
  task automatic runPattern(input int d, input int f, input int frames);
    int half, bitLen, frameLen, cyc, lastClkEdge, lastFsFall, strobes, fsFalls;
    bit prevClk, prevFs, pending;
    half = d + 1;
    bitLen = 2 * half;
    frameLen = (f + 1) * bitLen;
    clkDiv = CW'(d);
    frameDiv = FW'(f);
    enable = 1'b1;
    @(negedge clk);
    check(frameSyncN == 1'b0, "R7 sync low at start", int'(frameSyncN), 0);
    check(bitClk == 1'b0, "R7 bitClk low at start", int'(bitClk), 0);
    cyc = 0; lastClkEdge = 0; lastFsFall = 0; strobes = 0; fsFalls = 1;
    prevClk = 1'b0; prevFs = 1'b0; pending = 1'b1;
    for (int n = 1; n <= frames * frameLen; n++) begin
      @(negedge clk);
      cyc++;
      if (bitClk != prevClk) begin
        check(cyc - lastClkEdge == half, "R2 bitClk phase length", cyc - lastClkEdge, half);
        lastClkEdge = cyc;
        if (bitClk) begin
          check(bitStrobe == 1'b1, "R6 strobe on rise", int'(bitStrobe), 1);
          if (pending) begin
            check(cyc - lastFsFall == half, "R4 half-bit lead of sync", cyc - lastFsFall, half);
            pending = 1'b0;
          end
        end
      end else if (bitStrobe) begin
        check(1'b0, "R6 strobe without rise", 1, 0);
      end
      if (prevFs && !frameSyncN) begin
        check(prevClk && !bitClk, "R4 sync falls with bitClk fall", int'(bitClk), 0);
        check(cyc - lastFsFall == frameLen, "R5 frame period", cyc - lastFsFall, frameLen);
        check(strobes == f + 1, "R5 strobes per frame", strobes, f + 1);
        strobes = 0; lastFsFall = cyc; pending = 1'b1; fsFalls++;
      end
      if (!prevFs && frameSyncN)
        check(cyc - lastFsFall == bitLen, "R3 sync width", cyc - lastFsFall, bitLen);
      if (bitStrobe) strobes++;
      prevClk = bitClk;
      prevFs = frameSyncN;
    end
    check(fsFalls == frames + 1, "R5 sync count", fsFalls, frames + 1);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // R8: both dividers rewritten a few cycles into a frame
  task automatic testDivChange();
    int cyc, nFalls;
    int falls[3];
    bit prevFs;
    clkDiv = CW'(1);
    frameDiv = FW'(3);
    enable = 1'b1;
    @(negedge clk);
    cyc = 0; nFalls = 1; falls[0] = 0; prevFs = frameSyncN;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      cyc++;
      if (cyc == 5) begin
        clkDiv = CW'(2);
        frameDiv = FW'(1);
      end
      if (prevFs && !frameSyncN && nFalls < 3) begin
        falls[nFalls] = cyc;
        nFalls++;
      end
      prevFs = frameSyncN;
    end
    check(nFalls == 3, "R8 sync falls seen", nFalls, 3);
    check(falls[1] == 16, "R8 old frame kept", falls[1], 16);
    check(falls[2] - falls[1] == 12, "R8 new frame applied", falls[2] - falls[1], 12);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // R1 and R9: disable in mid-frame, then restart with a new divider
  task automatic testDisable();
    int firstRise;
    clkDiv = CW'(2);
    frameDiv = FW'(3);
    enable = 1'b1;
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(bitClk == 1'b0, "R1 disable bitClk", int'(bitClk), 0);
    check(frameSyncN == 1'b1, "R1 disable frameSyncN", int'(frameSyncN), 1);
    check(bitStrobe == 1'b0, "R1 disable bitStrobe", int'(bitStrobe), 0);
    repeat (4) @(negedge clk);
    check(bitClk == 1'b0 && frameSyncN == 1'b1, "R1 idle held", int'(frameSyncN), 1);
    clkDiv = CW'(1);
    enable = 1'b1;
    @(negedge clk);
    check(frameSyncN == 1'b0, "R9 restart sync low", int'(frameSyncN), 0);
    check(bitClk == 1'b0, "R9 restart bitClk low", int'(bitClk), 0);
    firstRise = 0;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (bitClk && firstRise == 0) firstRise = n;
    end
    check(firstRise == 2, "R9 restart first rise", firstRise, 2);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    runPattern(0, 3, 3);
    runPattern(2, 7, 2);
    runPattern(0, 1023, 2);
    runPattern(1, 1023, 1);
    testDivChange();
    testDisable();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule